// File: doc/BRIEF.md
# Multi-Timer Event Counter with Periodic Comparators

This block is a memory-mapped event timer. A 64-bit main counter counts up by one per clock while a global run bit is set. A small set of comparator timers each watch the counter and flag a match when the counter equals their comparator. On a match the timer sets a sticky status bit. If its interrupt is enabled, it also sends a one-cycle pulse on an output line chosen by a route field.

A timer can run one-shot or periodic. In periodic mode the main counter is never reset. Instead, each match adds a stored period to the comparator, so software can see that a tick happened because the comparator value changed. A set-value bit in the timer's configuration opens a two-write sequence: the first comparator write sets the next match value and the second sets the period. A narrow mode limits the compare and the periodic advance to the low 32 bits. A legacy-routing bit takes timers 0 and 1 off the routed lines and puts them on two fixed lines: a periodic-tick line and a clock-alarm line.

Software reaches everything through a simple single-cycle register port with a combinational read. Register offsets (byte addresses):

- 0x00: capability word.
- 0x04: tick period in femtoseconds.
- 0x08: global configuration.
- 0x0C: status.
- 0x10 and 0x14: the counter's low and high halves.
- 0x20 + 0x10*n: the block for timer n, with its configuration at +0, comparator low at +4 and comparator high at +8.

Top module: `tick_timer_top`

## Requirements
- R1: After reset the counter reads 0, run and legacy bits are 0, status reads 0, all interrupt outputs are low, the capability word at 0x00 reads NUM_TIMERS-1 in bits [4:0] with bit 8 set (legacy routing supported), and 0x04 reads PERIOD_FS.
- R2: Global configuration bit 0 (run) makes the counter advance by exactly one per clock; with it clear the counter holds its value.
- R3: Writes to 0x10 (bits [31:0]) and 0x14 (bits [63:32]) load the counter only while run is 0; such writes while running are ignored.
- R4: When the counter equals a timer's comparator while running, that timer's status bit n at 0x0C is set at the same edge; it stays set until software writes 1 to bit n.
- R5: Timer configuration bit 0 enables the interrupt; with it set, a match produces a one-cycle high pulse on irqLines[route] in the cycle after the counter held the comparator value, where route is configuration bits [9:8]; with it clear no line pulses.
- R6: With global configuration bit 1 (legacy) set, timer 0 pulses legacyTickIrq and timer 1 pulses legacyRtcIrq instead of their routed lines; with it clear neither legacy output is ever asserted.
- R7: With configuration bit 1 (periodic) set, each match adds the stored period to the comparator while the counter keeps counting.
- R8: With the periodic bit clear the comparator is left unchanged by a match.
- R9: Writing configuration bit 2 (set-value) to 1 on a periodic timer makes the next comparator-low write load the comparator and the following one load the period, and bit 2 then reads 0. On a non-periodic timer the first comparator-low write loads the comparator and clears bit 2.
- R10: With configuration bit 3 (narrow) set, only bits [31:0] take part in the match, and the periodic advance wraps within bits [31:0], leaving bits [63:32] of the comparator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 8 | Register byte address |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data, combinational from busAddr |
| irqLines | output | NUM_LINES | Routed interrupt pulses |
| legacyTickIrq | output | 1 | Legacy periodic-tick interrupt pulse |
| legacyRtcIrq | output | 1 | Legacy clock-alarm interrupt pulse |

## Verification
The properties assume that busWr and busAddr are known at every clock edge after reset, and that a status clear is the only path that can lower a status bit. They also assume that software moves the counter only through the two counter addresses. The stimulus changes bus inputs only at falling edges and writes the counter halves only while run is clear; one write made while running checks that it is dropped. Before each timed window the counter is zeroed or preset while halted. Periods are drawn from 3 to 12 and first match values from 5 to 15, so successive pulses are always apart and can be counted one by one.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int CNT_W  = 64;
  localparam int HALF_W = 32;

  // global register addresses
  localparam logic [7:0] A_CAP    = 8'h00;
  localparam logic [7:0] A_PERIOD = 8'h04;
  localparam logic [7:0] A_GCFG   = 8'h08;
  localparam logic [7:0] A_STATUS = 8'h0C;
  localparam logic [7:0] A_CNT_LO = 8'h10;
  localparam logic [7:0] A_CNT_HI = 8'h14;

  // per-timer block: upper nibble = timer + TB_BASE_NIB, lower nibble = offset
  localparam int         TB_BASE_NIB = 2;
  localparam logic [3:0] T_CFG    = 4'h0;
  localparam logic [3:0] T_CMP_LO = 4'h4;
  localparam logic [3:0] T_CMP_HI = 4'h8;

  // bit positions
  localparam int G_RUN       = 0;
  localparam int G_LEGACY    = 1;
  localparam int C_INTEN     = 0;
  localparam int C_PERIODIC  = 1;
  localparam int C_SETVAL    = 2;
  localparam int C_NARROW    = 3;
  localparam int C_ROUTE_LSB = 8;
  localparam int CAP_LEG_BIT = 8;

  typedef struct packed {
    logic cntLo;
    logic cntHi;
  } cntStrobe_t;

  typedef struct packed {
    logic cmpLo;
    logic cmpHi;
    logic perLo;
    logic perHi;
  } tmrStrobe_t;
endpackage

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int NUM_TIMERS = 3
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  runOn,
  input  cntStrobe_t                            cntStrb,
  input  tmrStrobe_t [NUM_TIMERS-1:0]           tmrStrb,
  input  logic [HALF_W-1:0]                     wdata,
  input  logic [NUM_TIMERS-1:0]                 periodicVec,
  input  logic [NUM_TIMERS-1:0]                 narrowVec,
  output logic [CNT_W-1:0]                      cntVal,
  output logic [NUM_TIMERS-1:0][CNT_W-1:0]      cmpVals,
  output logic [NUM_TIMERS-1:0]                 matchVec
);

  // main counter: loads only while halted (control gates the strobes)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (runOn) begin
      cntVal <= cntVal + 1'b1;
    end else begin
      if (cntStrb.cntLo) cntVal[HALF_W-1:0]     <= wdata;
      if (cntStrb.cntHi) cntVal[CNT_W-1:HALF_W] <= wdata;
    end
  end

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_cmp
    logic [CNT_W-1:0] cmpReg;
    logic [CNT_W-1:0] perReg;
    logic             eqWide;
    logic             eqNarrow;

    assign eqWide      = (cntVal == cmpReg);
    assign eqNarrow    = (cntVal[HALF_W-1:0] == cmpReg[HALF_W-1:0]);
    assign matchVec[i] = runOn && (narrowVec[i] ? eqNarrow : eqWide);
    assign cmpVals[i]  = cmpReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmpReg <= '1;
        perReg <= '0;
      end else begin
        if (tmrStrb[i].cmpLo || tmrStrb[i].cmpHi) begin
          if (tmrStrb[i].cmpLo) cmpReg[HALF_W-1:0]     <= wdata;
          if (tmrStrb[i].cmpHi) cmpReg[CNT_W-1:HALF_W] <= wdata;
        end else if (matchVec[i] && periodicVec[i]) begin
          if (narrowVec[i])
            cmpReg[HALF_W-1:0] <= cmpReg[HALF_W-1:0] + perReg[HALF_W-1:0];
          else
            cmpReg <= cmpReg + perReg;
        end
        if (tmrStrb[i].perLo) perReg[HALF_W-1:0]     <= wdata;
        if (tmrStrb[i].perHi) perReg[CNT_W-1:HALF_W] <= wdata;
      end
    end
  end

endmodule

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int          NUM_TIMERS = 3,
  parameter int          NUM_LINES  = 4,
  parameter logic [31:0] PERIOD_FS  = 32'd10000000
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              busWr,
  input  logic [7:0]                        busAddr,
  input  logic [HALF_W-1:0]                 busWdata,
  output logic [HALF_W-1:0]                 busRdata,
  input  logic [NUM_TIMERS-1:0]             matchVec,
  input  logic [CNT_W-1:0]                  cntVal,
  input  logic [NUM_TIMERS-1:0][CNT_W-1:0]  cmpVals,
  output cntStrobe_t                        cntStrb,
  output tmrStrobe_t [NUM_TIMERS-1:0]       tmrStrb,
  output logic                              runOn,
  output logic                              legacyOn,
  output logic [NUM_TIMERS-1:0]             periodicVec,
  output logic [NUM_TIMERS-1:0]             narrowVec,
  output logic [NUM_TIMERS-1:0]             intEnVec,
  output logic [NUM_TIMERS-1:0]             statusVec,
  output logic [NUM_LINES-1:0]              irqLines,
  output logic                              legacyTickIrq,
  output logic                              legacyRtcIrq
);
  localparam int RW = (NUM_LINES  > 1) ? $clog2(NUM_LINES)  : 1;
  localparam int IW = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1;

  logic [3:0]                         tNib;
  logic [3:0]                         tOff;
  logic [IW-1:0]                      tSel;
  logic                               tValid;
  logic [NUM_TIMERS-1:0][RW-1:0]      routeVec;
  logic [NUM_TIMERS-1:0][HALF_W-1:0]  cfgWords;
  logic [NUM_TIMERS-1:0]              clrMask;
  logic [NUM_LINES-1:0]               lineNext;
  logic                               tickNext;
  logic                               rtcNext;
  logic                               gcfgWr;

  assign tNib   = busAddr[7:4];
  assign tOff   = busAddr[3:0];
  assign tSel   = tNib[IW-1:0] - IW'(TB_BASE_NIB);
  assign tValid = (int'(tNib) >= TB_BASE_NIB) && ((int'(tNib) - TB_BASE_NIB) < NUM_TIMERS);
  assign gcfgWr = busWr && (busAddr == A_GCFG);

  // counter halves are writable only while halted
  assign cntStrb.cntLo = busWr && (busAddr == A_CNT_LO) && !runOn;
  assign cntStrb.cntHi = busWr && (busAddr == A_CNT_HI) && !runOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runOn    <= 1'b0;
      legacyOn <= 1'b0;
    end else if (gcfgWr) begin
      runOn    <= busWdata[G_RUN];
      legacyOn <= busWdata[G_LEGACY];
    end
  end

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    logic          hit, cfgWr, loWr, hiWr;
    logic          intEn, periodic, setVal, narrow, toPeriod;
    logic [RW-1:0] route;

    assign hit   = busWr && (tNib == 4'(i + TB_BASE_NIB));
    assign cfgWr = hit && (tOff == T_CFG);
    assign loWr  = hit && (tOff == T_CMP_LO);
    assign hiWr  = hit && (tOff == T_CMP_HI);

    // second half of a set-value sequence steers writes to the period
    assign tmrStrb[i].cmpLo = loWr && !toPeriod;
    assign tmrStrb[i].cmpHi = hiWr && !toPeriod;
    assign tmrStrb[i].perLo = loWr && toPeriod;
    assign tmrStrb[i].perHi = hiWr && toPeriod;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        intEn    <= 1'b0;
        periodic <= 1'b0;
        setVal   <= 1'b0;
        narrow   <= 1'b0;
        toPeriod <= 1'b0;
        route    <= '0;
      end else if (cfgWr) begin
        intEn    <= busWdata[C_INTEN];
        periodic <= busWdata[C_PERIODIC];
        setVal   <= busWdata[C_SETVAL];
        narrow   <= busWdata[C_NARROW];
        route    <= busWdata[C_ROUTE_LSB +: RW];
        toPeriod <= 1'b0;
      end else if (loWr && setVal) begin
        if (periodic && !toPeriod) begin
          toPeriod <= 1'b1;
        end else begin
          setVal   <= 1'b0;
          toPeriod <= 1'b0;
        end
      end
    end

    always_comb begin
      cfgWords[i]                   = '0;
      cfgWords[i][C_INTEN]          = intEn;
      cfgWords[i][C_PERIODIC]       = periodic;
      cfgWords[i][C_SETVAL]         = setVal;
      cfgWords[i][C_NARROW]         = narrow;
      cfgWords[i][C_ROUTE_LSB +: RW] = route;
    end

    assign intEnVec[i]    = intEn;
    assign periodicVec[i] = periodic;
    assign narrowVec[i]   = narrow;
    assign routeVec[i]    = route;
  end

  // sticky status, write one to clear, a new match wins
  assign clrMask = (busWr && (busAddr == A_STATUS)) ? busWdata[NUM_TIMERS-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusVec <= '0;
    else       statusVec <= (statusVec & ~clrMask) | matchVec;
  end

  // interrupt routing
  always_comb begin
    lineNext = '0;
    tickNext = 1'b0;
    rtcNext  = 1'b0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (matchVec[i] && intEnVec[i]) begin
        if (legacyOn && (i == 0))      tickNext = 1'b1;
        else if (legacyOn && (i == 1)) rtcNext  = 1'b1;
        else                           lineNext[routeVec[i]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqLines      <= '0;
      legacyTickIrq <= 1'b0;
      legacyRtcIrq  <= 1'b0;
    end else begin
      irqLines      <= lineNext;
      legacyTickIrq <= tickNext;
      legacyRtcIrq  <= rtcNext;
    end
  end

  // combinational read
  always_comb begin
    busRdata = '0;
    case (busAddr)
      A_CAP:    begin
                  busRdata[4:0]       = 5'(NUM_TIMERS - 1);
                  busRdata[CAP_LEG_BIT] = 1'b1;
                end
      A_PERIOD: busRdata = PERIOD_FS;
      A_GCFG:   begin
                  busRdata[G_RUN]    = runOn;
                  busRdata[G_LEGACY] = legacyOn;
                end
      A_STATUS: busRdata[NUM_TIMERS-1:0] = statusVec;
      A_CNT_LO: busRdata = cntVal[HALF_W-1:0];
      A_CNT_HI: busRdata = cntVal[CNT_W-1:HALF_W];
      default: begin
        if (tValid) begin
          case (tOff)
            T_CFG:    busRdata = cfgWords[tSel];
            T_CMP_LO: busRdata = cmpVals[tSel][HALF_W-1:0];
            T_CMP_HI: busRdata = cmpVals[tSel][CNT_W-1:HALF_W];
            default:  busRdata = '0;
          endcase
        end
      end
    endcase
  end

endmodule

// File: rtl/tick_timer_top.sv
module tick_timer_top
  import tick_timer_pkg::*;
#(
  parameter int          NUM_TIMERS = 3,
  parameter int          NUM_LINES  = 4,
  parameter logic [31:0] PERIOD_FS  = 32'd10000000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWr,
  input  logic [7:0]           busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output logic [NUM_LINES-1:0] irqLines,
  output logic                 legacyTickIrq,
  output logic                 legacyRtcIrq
);
  cntStrobe_t                        cntStrb;
  tmrStrobe_t [NUM_TIMERS-1:0]       tmrStrb;
  logic                              runOn;
  logic                              legacyOn;
  logic [NUM_TIMERS-1:0]             periodicVec;
  logic [NUM_TIMERS-1:0]             narrowVec;
  logic [NUM_TIMERS-1:0]             intEnVec;
  logic [NUM_TIMERS-1:0]             statusVec;
  logic [NUM_TIMERS-1:0]             matchVec;
  logic [CNT_W-1:0]                  cntVal;
  logic [NUM_TIMERS-1:0][CNT_W-1:0]  cmpVals;

  tick_timer_ctrl #(
    .NUM_TIMERS(NUM_TIMERS), .NUM_LINES(NUM_LINES), .PERIOD_FS(PERIOD_FS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .matchVec(matchVec),
    .cntVal(cntVal), .cmpVals(cmpVals), .cntStrb(cntStrb), .tmrStrb(tmrStrb),
    .runOn(runOn), .legacyOn(legacyOn), .periodicVec(periodicVec),
    .narrowVec(narrowVec), .intEnVec(intEnVec), .statusVec(statusVec),
    .irqLines(irqLines), .legacyTickIrq(legacyTickIrq), .legacyRtcIrq(legacyRtcIrq)
  );

  tick_timer_dp #(.NUM_TIMERS(NUM_TIMERS)) u_dp (
    .clk(clk), .rstN(rstN), .runOn(runOn), .cntStrb(cntStrb), .tmrStrb(tmrStrb),
    .wdata(busWdata), .periodicVec(periodicVec), .narrowVec(narrowVec),
    .cntVal(cntVal), .cmpVals(cmpVals), .matchVec(matchVec)
  );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int NUM_TIMERS = 3,
  parameter int NUM_LINES  = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  runOn,
  input logic                  legacyOn,
  input logic                  cntWr,
  input logic                  statusWr,
  input logic [63:0]           cntVal,
  input logic [NUM_TIMERS-1:0] matchVec,
  input logic [NUM_TIMERS-1:0] intEnVec,
  input logic [NUM_TIMERS-1:0] statusVec,
  input logic [NUM_LINES-1:0]  irqLines,
  input logic                  legacyTickIrq,
  input logic                  legacyRtcIrq
);

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    runOn |=> (cntVal == $past(cntVal) + 64'd1));

  assert_halt_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!runOn && !cntWr) |=> $stable(cntVal));

  assert_match_sets_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|matchVec) |=> ((statusVec & $past(matchVec)) == $past(matchVec)));

  assert_status_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    !statusWr |=> ((statusVec & $past(statusVec)) == $past(statusVec)));

  assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|irqLines) |-> $past(|(matchVec & intEnVec)));

  assert_legacy_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !legacyOn |=> !(legacyTickIrq || legacyRtcIrq));

endmodule

bind tick_timer_top tick_timer_chk #(.NUM_TIMERS(NUM_TIMERS), .NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rstN(rstN), .runOn(runOn), .legacyOn(legacyOn),
  .cntWr(busWr && ((busAddr == tick_timer_pkg::A_CNT_LO) || (busAddr == tick_timer_pkg::A_CNT_HI))),
  .statusWr(busWr && (busAddr == tick_timer_pkg::A_STATUS)),
  .cntVal(cntVal), .matchVec(matchVec), .intEnVec(intEnVec), .statusVec(statusVec),
  .irqLines(irqLines), .legacyTickIrq(legacyTickIrq), .legacyRtcIrq(legacyRtcIrq)
);

// File: tb/tick_timer_top_bench.sv
`timescale 1ns/1ps
module tick_timer_top_bench;
  localparam int NT = 3;
  localparam int NL = 4;
  localparam logic [31:0] PFS = 32'd10000000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWdata = 32'h0;
  logic [31:0] busRdata;
  logic [NL-1:0] irqLines;
  logic        legacyTickIrq, legacyRtcIrq;

  int total = 0;
  int bad = 0;
  logic [31:0] rv, rv2;
  int firstK, nPulse, firstK2, nOther;
  int unsigned seedInit;

  always #4 clk = ~clk;

  tick_timer_top #(.NUM_TIMERS(NT), .NUM_LINES(NL), .PERIOD_FS(PFS)) u_tick_timer_top (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqLines(irqLines), .legacyTickIrq(legacyTickIrq),
    .legacyRtcIrq(legacyRtcIrq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk);
    #1 busWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic zeroCounter();
    wr(8'h08, 32'h0);
    wr(8'h10, 32'h0);
    wr(8'h14, 32'h0);
  endtask

  // sample one routed line over w falling edges after a run write
  task automatic watchLine(input int line, input int w, output int fk, output int np);
    fk = -1; np = 0;
    for (int k = 0; k < w; k++) begin
      @(negedge clk);
      if (irqLines[line]) begin
        np++;
        if (fk < 0) fk = k;
      end
    end
  endtask

  function automatic int expPulses(int c, int p, int w);
    int n = 0;
    for (int m = c; m <= w - 2; m += p) n++;
    return n;
  endfunction

  function automatic int expCmp(int c, int p, int w);
    int v = c;
    while (v <= w) v += p;
    return v;
  endfunction

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    seedInit = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    rd(8'h00, rv); chk("R1 capability", rv, 32'h102);
    rd(8'h04, rv); chk("R1 period", rv, PFS);
    rd(8'h10, rv); chk("R1 counter", rv, 0);
    rd(8'h0C, rv); chk("R1 status", rv, 0);
    rd(8'h08, rv); chk("R1 gcfg", rv, 0);
    chk("R1 irq outputs", {irqLines, legacyTickIrq, legacyRtcIrq}, 0);

    // R2 counting, R3 write ignored while running
    wr(8'h08, 32'h1);
    rd(8'h10, rv); rd(8'h10, rv2); chk("R2 step", rv2, rv + 1);
    wr(8'h10, 32'h1234);
    rd(8'h10, rv); chk("R3 write while running ignored", rv, rv2 + 2);
    wr(8'h08, 32'h0);
    rd(8'h10, rv); repeat (3) @(negedge clk); rd(8'h10, rv2);
    chk("R2 halted holds", rv2, rv);
    wr(8'h10, 32'hAB); wr(8'h14, 32'h7);
    rd(8'h10, rv); chk("R3 load low", rv, 32'hAB);
    rd(8'h14, rv); chk("R3 load high", rv, 32'h7);
    zeroCounter();

    // timer 0: one-shot, set-value on non-periodic timer
    wr(8'h28, 32'h0);
    wr(8'h20, 32'h205);
    wr(8'h24, 32'd20);
    rd(8'h20, rv); chk("R9 set-value clears on one-shot", rv[2], 1'b0);
    rd(8'h24, rv); chk("R9 one-shot compare loaded", rv, 32'd20);
    wr(8'h08, 32'h1);
    watchLine(2, 30, firstK, nPulse);
    chk("R5 pulse cycle", firstK, 21);
    chk("R5 single pulse", nPulse, 1);
    wr(8'h08, 32'h0);
    rd(8'h24, rv); chk("R8 one-shot compare unchanged", rv, 32'd20);
    rd(8'h0C, rv); chk("R4 status set", rv[0], 1'b1);
    wr(8'h0C, 32'h1);
    rd(8'h0C, rv); chk("R4 status cleared", rv[0], 1'b0);

    // R5 interrupt disabled: status only
    wr(8'h20, 32'h200);
    zeroCounter();
    wr(8'h08, 32'h1);
    watchLine(2, 25, firstK, nPulse);
    chk("R5 disabled no pulse", nPulse, 0);
    wr(8'h08, 32'h0);
    rd(8'h0C, rv); chk("R4 status without irq", rv[0], 1'b1);
    wr(8'h0C, 32'h7);

    // timer 1: periodic rounds with random first value and period
    for (int r = 0; r < 4; r++) begin
      int c, p, w;
      c = 5 + int'($urandom % 11);
      p = 3 + int'($urandom % 10);
      w = 60;
      zeroCounter();
      wr(8'h38, 32'h0);
      wr(8'h30, 32'h107);
      rd(8'h30, rv); chk("R9 set-value armed", rv[2], 1'b1);
      wr(8'h34, 32'(c));
      rd(8'h30, rv); chk("R9 set-value mid sequence", rv[2], 1'b1);
      wr(8'h34, 32'(p));
      rd(8'h30, rv); chk("R9 set-value self-clears", rv[2], 1'b0);
      rd(8'h34, rv); chk("R9 first write is compare", rv, 32'(c));
      wr(8'h08, 32'h1);
      watchLine(1, w, firstK, nPulse);
      chk("R7 first periodic pulse", firstK, c + 1);
      chk("R7 periodic pulse count", nPulse, expPulses(c, p, w));
      wr(8'h08, 32'h0);
      rd(8'h34, rv); chk("R7 compare advanced", rv, 32'(expCmp(c, p, w)));
    end

    // R10 narrow mode with wrap of the low half
    wr(8'h08, 32'h0);
    wr(8'h10, 32'hFFFFFFF0); wr(8'h14, 32'h0);
    wr(8'h48, 32'h5);
    wr(8'h40, 32'h30F);
    wr(8'h44, 32'hFFFFFFF8);
    wr(8'h44, 32'd10);
    wr(8'h08, 32'h1);
    watchLine(3, 12, firstK, nPulse);
    chk("R10 narrow match pulse", firstK, 9);
    wr(8'h08, 32'h0);
    rd(8'h44, rv); chk("R10 low half wraps", rv, 32'h2);
    rd(8'h48, rv); chk("R10 high half kept", rv, 32'h5);

    // R6 legacy routing
    zeroCounter();
    wr(8'h20, 32'h205);
    wr(8'h24, 32'd5);
    wr(8'h34, 32'd8);
    wr(8'h08, 32'h3);
    firstK = -1; firstK2 = -1; nOther = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (legacyTickIrq && firstK < 0) firstK = k;
      if (legacyRtcIrq && firstK2 < 0) firstK2 = k;
      if (irqLines[2] || irqLines[1]) nOther++;
    end
    wr(8'h08, 32'h0);
    chk("R6 tick line from timer 0", firstK, 6);
    chk("R6 alarm line from timer 1", firstK2, 9);
    chk("R6 routed lines silent", nOther, 0);

    finishRun();
  end
endmodule